// File: doc/BRIEF.md
# Address Translation Buffer with Process Tags and Fixed Regions

This block turns a 32-bit virtual address into a physical address in one registered lookup. The top three address bits first pick one of four regions. Two kernel regions bypass translation: one is cached and one is uncached. The user region and the upper kernel region are translated. A translation compares the page number and the current process tag against every loaded entry at once.

Software owns the contents. On a miss, on a match with an entry marked not valid, or on a store to a page that is not writable, the block reports a fault code instead of a physical address. The handler then loads an entry through the write port at an index it chooses.

The response is registered: a request in one cycle gives its result in the next. There is no state machine; the only state is the entry storage and the response register.

Top module: `vtlb_xlate`

## Requirements
- R1: `rs_valid` is high in exactly the cycle after a cycle with `lk_req` high, and low otherwise. Reset clears `rs_valid` and unloads every entry, so a translated lookup straight after reset returns fault code 1.
- R2: Region decode in kernel mode uses the top address bits: bit 31 = 0 is the user region (translated); 100 is the direct cached region; 101 is the direct uncached region; 11 is the kernel translated region.
- R3: In the two direct regions the physical address is the virtual address with bits 31..29 cleared, and the fault code is 0. `rs_cached` is 1 for top bits 100 and 0 for top bits 101. No entry is consulted.
- R4: A translated hit on a valid entry returns `{pfn, vaddr[11:0]}` with fault code 0. `rs_cached` is the inverse of the entry's uncached bit.
- R5: An entry matches only when both its page number and its 6-bit process tag equal those of the lookup.
- R6: A translated lookup that matches no loaded entry returns fault code 1 (refill).
- R7: A match on an entry whose valid bit is 0 returns fault code 2 (invalid).
- R8: A store that hits a valid entry with its writable bit 0 returns fault code 3 (modify). A load to the same entry translates normally.
- R9: A user-mode lookup with address bit 31 set returns fault code 4 (address error), whatever the entries hold.
- R10: Whenever the fault code is nonzero, `rs_paddr` is 0 and `rs_cached` is 0.
- R11: A write loads the entry at `wr_idx`; any of the 64 indices can be loaded. A lookup in the same cycle as the write sees the old contents, and a lookup in the next cycle sees the new contents. Rewriting an index removes the mapping it held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address |
| lk_store | input | 1 | Lookup is for a store |
| lk_user_mode | input | 1 | Access made in user mode |
| cur_asid | input | 6 | Current process tag |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 6 | Entry index to load |
| wr_vpn | input | 20 | Virtual page number of new entry |
| wr_asid | input | 6 | Process tag of new entry |
| wr_pfn | input | 20 | Physical frame number of new entry |
| wr_valid | input | 1 | Valid bit of new entry |
| wr_dirty | input | 1 | Writable bit of new entry |
| wr_nocache | input | 1 | Uncached bit of new entry |
| rs_valid | output | 1 | Response present |
| rs_paddr | output | 32 | Physical address (0 on fault) |
| rs_cached | output | 1 | Access may be cached |
| rs_fault | output | 3 | 0 none, 1 refill, 2 invalid, 3 modify, 4 address error |

## Verification
The match-vector assertion assumes software never loads two entries with the same page number and process tag. A duplicate would make two entries hit at once. The bench always uses distinct page and tag pairs. When it rewrites an index, the old pair leaves as the new one arrives, so no duplicate ever exists. The response assertions also assume `lk_req` is held low while reset is asserted, and the bench keeps it low until reset is released.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_OFS = 12;
    localparam int VPN_W  = VA_W - PG_OFS;
    localparam int PFN_W  = 20;
    localparam int ASID_W = 6;

    typedef enum logic [1:0] {
        RGN_USER      = 2'd0,
        RGN_KDIRECT_C = 2'd1,
        RGN_KDIRECT_U = 2'd2,
        RGN_KMAPPED   = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_REFILL  = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_MODIFY  = 3'd3,
        FLT_ADDR    = 3'd4
    } fault_e;

    typedef struct packed {
        logic              loaded;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              valid;
        logic              dirty;
        logic              nocache;
    } tlb_ent_t;
endpackage

// File: rtl/vtlb_region_dec.sv
module vtlb_region_dec
    import vtlb_pkg::*;
(
    input  logic [2:0] va_top,
    output region_e    region
);
    always_comb begin
        if (!va_top[2]) begin
            region = RGN_USER;
        end else begin
            unique case (va_top[1:0])
                2'b00:   region = RGN_KDIRECT_C;
                2'b01:   region = RGN_KDIRECT_U;
                default: region = RGN_KMAPPED;
            endcase
        end
    end
endmodule

// File: rtl/vtlb_cam.sv
module vtlb_cam
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_ent_t          wr_ent,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              hit,
    output logic              hit_valid,
    output logic              hit_dirty,
    output logic              hit_nocache,
    output logic [PFN_W-1:0]  hit_pfn
);
    tlb_ent_t           ents [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
        end else if (wr_en) begin
            ents[wr_idx] <= wr_ent;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ents[g].loaded && (ents[g].vpn == lk_vpn)
                          && (ents[g].asid == lk_asid);
    end

    always_comb begin
        hit         = |match;
        hit_valid   = 1'b0;
        hit_dirty   = 1'b0;
        hit_nocache = 1'b0;
        hit_pfn     = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_valid   = ents[i].valid;
                hit_dirty   = ents[i].dirty;
                hit_nocache = ents[i].nocache;
                hit_pfn     = ents[i].pfn;
            end
        end
    end

    // R5
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_store,
    input  logic              lk_user_mode,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              wr_nocache,
    output logic              rs_valid,
    output logic [VA_W-1:0]   rs_paddr,
    output logic              rs_cached,
    output logic [2:0]        rs_fault
);
    region_e          rgn;
    tlb_ent_t         new_ent;
    logic             hit, hit_valid, hit_dirty, hit_nocache;
    logic [PFN_W-1:0] hit_pfn;
    fault_e           flt_d;
    logic [VA_W-1:0]  pa_d;
    logic             cch_d;

    assign new_ent = '{loaded: 1'b1, vpn: wr_vpn, asid: wr_asid, pfn: wr_pfn,
                       valid: wr_valid, dirty: wr_dirty, nocache: wr_nocache};

    vtlb_region_dec u_dec (
        .va_top (lk_vaddr[VA_W-1 -: 3]),
        .region (rgn)
    );

    vtlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cam (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_ent      (new_ent),
        .lk_vpn      (lk_vaddr[VA_W-1:PG_OFS]),
        .lk_asid     (cur_asid),
        .hit         (hit),
        .hit_valid   (hit_valid),
        .hit_dirty   (hit_dirty),
        .hit_nocache (hit_nocache),
        .hit_pfn     (hit_pfn)
    );

    always_comb begin
        flt_d = FLT_NONE;
        pa_d  = '0;
        cch_d = 1'b0;
        if (lk_user_mode && lk_vaddr[VA_W-1]) begin
            flt_d = FLT_ADDR;
        end else begin
            unique case (rgn)
                RGN_KDIRECT_C: begin
                    pa_d  = {3'b000, lk_vaddr[VA_W-4:0]};
                    cch_d = 1'b1;
                end
                RGN_KDIRECT_U: begin
                    pa_d  = {3'b000, lk_vaddr[VA_W-4:0]};
                end
                RGN_USER, RGN_KMAPPED: begin
                    if (!hit)                         flt_d = FLT_REFILL;
                    else if (!hit_valid)              flt_d = FLT_INVALID;
                    else if (lk_store && !hit_dirty)  flt_d = FLT_MODIFY;
                    else begin
                        pa_d  = {hit_pfn, lk_vaddr[PG_OFS-1:0]};
                        cch_d = !hit_nocache;
                    end
                end
                default: flt_d = FLT_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid  <= 1'b0;
            rs_paddr  <= '0;
            rs_cached <= 1'b0;
            rs_fault  <= FLT_NONE;
        end else begin
            rs_valid  <= lk_req;
            rs_paddr  <= pa_d;
            rs_cached <= cch_d;
            rs_fault  <= flt_d;
        end
    end

    // R1
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rs_valid);
    // R1
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rs_valid);
    // R9
    user_kernel_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_user_mode && lk_vaddr[VA_W-1]) |=> (rs_fault == FLT_ADDR));
    // R3
    direct_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_user_mode && lk_vaddr[VA_W-1 -: 3] == 3'b101) |=>
        (rs_paddr == {3'b000, $past(lk_vaddr[VA_W-4:0])} && !rs_cached
         && rs_fault == FLT_NONE));
    // R10
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_fault != FLT_NONE) |-> (rs_paddr == '0 && !rs_cached));
    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (rs_fault != FLT_NONE
                    || rs_paddr[PG_OFS-1:0] == $past(lk_vaddr[PG_OFS-1:0])));
endmodule

// File: tb/sim_vtlb_xlate.sv
module sim_vtlb_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_store = 1'b0, lk_user_mode = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  cur_asid = '0;
    logic        wr_en = 1'b0, wr_valid = 1'b0, wr_dirty = 1'b0, wr_nocache = 1'b0;
    logic [5:0]  wr_idx = '0, wr_asid = '0;
    logic [19:0] wr_vpn = '0, wr_pfn = '0;
    logic        rs_valid, rs_cached;
    logic [31:0] rs_paddr;
    logic [2:0]  rs_fault;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtlb_xlate u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_store(lk_store), .lk_user_mode(lk_user_mode), .cur_asid(cur_asid),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_pfn(wr_pfn), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
        .wr_nocache(wr_nocache), .rs_valid(rs_valid), .rs_paddr(rs_paddr),
        .rs_cached(rs_cached), .rs_fault(rs_fault)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic load_ent(input logic [5:0] idx, input logic [19:0] vpn,
                            input logic [5:0] asid, input logic [19:0] pfn,
                            input logic v, input logic d, input logic nc);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid;
        wr_pfn = pfn; wr_valid = v; wr_dirty = d; wr_nocache = nc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic st,
                          input logic um, input logic [5:0] asid);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va; lk_store = st;
        lk_user_mode = um; cur_asid = asid;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic expect_resp(input string req, input logic [31:0] pa,
                               input logic c, input logic [2:0] f);
        chk({req, " valid"}, {31'b0, rs_valid}, 32'd1);
        chk({req, " paddr"}, rs_paddr, pa);
        chk({req, " cached"}, {31'b0, rs_cached}, {31'b0, c});
        chk({req, " fault"}, {29'b0, rs_fault}, {29'b0, f});
    endtask

    task automatic t_reset;
        chk("R1 reset valid", {31'b0, rs_valid}, 32'd0);
        lookup(32'h0040_0123, 1'b0, 1'b1, 6'd3);
        expect_resp("R1 empty after reset", 32'h0, 1'b0, 3'd1);
        @(negedge clk);
        chk("R1 valid drops", {31'b0, rs_valid}, 32'd0);
    endtask

    task automatic t_direct;
        lookup(32'h8012_3456, 1'b0, 1'b0, 6'd0);
        expect_resp("R3 R2 direct cached", 32'h0012_3456, 1'b1, 3'd0);
        lookup(32'hBFFF_FFFC, 1'b0, 1'b0, 6'd0);
        expect_resp("R3 R2 direct uncached", 32'h1FFF_FFFC, 1'b0, 3'd0);
    endtask

    task automatic t_user_err;
        lookup(32'h8000_0000, 1'b0, 1'b1, 6'd3);
        expect_resp("R9 user to kernel", 32'h0, 1'b0, 3'd4);
        lookup(32'hC000_1ABC, 1'b0, 1'b1, 6'd3);
        expect_resp("R9 user to mapped kernel", 32'h0, 1'b0, 3'd4);
    endtask

    task automatic t_hit_asid;
        load_ent(6'd5, 20'h00400, 6'd3, 20'h12345, 1'b1, 1'b1, 1'b0);
        lookup(32'h0040_0123, 1'b1, 1'b1, 6'd3);
        expect_resp("R4 user hit", 32'h1234_5123, 1'b1, 3'd0);
        lookup(32'h0040_0123, 1'b0, 1'b1, 6'd4);
        expect_resp("R5 R6 tag mismatch", 32'h0, 1'b0, 3'd1);
        lookup(32'h0040_1123, 1'b0, 1'b1, 6'd3);
        expect_resp("R6 page miss", 32'h0, 1'b0, 3'd1);
    endtask

    task automatic t_modify_invalid;
        load_ent(6'd7, 20'h00500, 6'd3, 20'h0ABCD, 1'b1, 1'b0, 1'b1);
        lookup(32'h0050_0FFF, 1'b1, 1'b1, 6'd3);
        expect_resp("R8 R10 store no write", 32'h0, 1'b0, 3'd3);
        lookup(32'h0050_0FFF, 1'b0, 1'b1, 6'd3);
        expect_resp("R8 load ok", 32'h0ABC_DFFF, 1'b0, 3'd0);
        load_ent(6'd8, 20'h00600, 6'd3, 20'h0BEEF, 1'b0, 1'b1, 1'b0);
        lookup(32'h0060_0010, 1'b0, 1'b1, 6'd3);
        expect_resp("R7 invalid entry", 32'h0, 1'b0, 3'd2);
    endtask

    task automatic t_kmapped;
        load_ent(6'd63, 20'hC0001, 6'd9, 20'hFEDCB, 1'b1, 1'b1, 1'b1);
        lookup(32'hC000_1ABC, 1'b0, 1'b0, 6'd9);
        expect_resp("R2 R4 kernel mapped idx63", 32'hFEDC_BABC, 1'b0, 3'd0);
        lookup(32'hC000_1ABC, 1'b0, 1'b0, 6'd8);
        expect_resp("R5 kernel mapped wrong tag", 32'h0, 1'b0, 3'd1);
    endtask

    task automatic t_write_timing;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd5; wr_vpn = 20'h00700; wr_asid = 6'd3;
        wr_pfn = 20'h00777; wr_valid = 1'b1; wr_dirty = 1'b1; wr_nocache = 1'b0;
        lk_req = 1'b1; lk_vaddr = 32'h0070_0004; lk_store = 1'b0;
        lk_user_mode = 1'b1; cur_asid = 6'd3;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        expect_resp("R11 same-cycle sees old", 32'h0, 1'b0, 3'd1);
        lookup(32'h0070_0004, 1'b0, 1'b1, 6'd3);
        expect_resp("R11 next cycle sees new", 32'h0077_7004, 1'b1, 3'd0);
        lookup(32'h0040_0123, 1'b0, 1'b1, 6'd3);
        expect_resp("R11 old mapping gone", 32'h0, 1'b0, 3'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_user_err();
        t_hit_asid();
        t_modify_invalid();
        t_kmapped();
        t_write_timing();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule